// File: doc/BRIEF.md
# Four-Phase Word Handshake Across Clock Domains

This block carries one data word at a time from a sending clock domain into an unrelated receiving clock domain. The sender offers a word with `s_valid_i` while `s_ready_o` is high. The block stores that word in a holding register in the sending domain and raises a request flag. Only the request and the returning acknowledge pass through multi-flop synchronizers. The data bus is never synchronized bit by bit. It reaches the receiver directly from the holding register, which stays unchanged for the whole handshake.

The receiver watches the synchronized request. On its rising edge the receiver samples the bus, presents the word on `r_data_o` and pulses `r_valid_o` for one cycle. It also raises the acknowledge. The sender drops its request once it sees the acknowledge. The receiver then drops the acknowledge once the request has gone. The sender becomes ready again only after it sees the acknowledge low. Each synchronized edge may land one or two destination cycles after it changes, and nothing in the block depends on the exact latency.

Top module: `cdc_word_handshake`

## Requirements
- R1: While the resets are applied (synchronous, active high, one per domain), the request, the acknowledge and every synchronizer stage are cleared. After both resets are released and before any transfer, `s_ready_o` is 1, `r_valid_o` is 0 and `r_data_o` is 0.
- R2: When `s_valid_i` and `s_ready_o` are both 1 at a rising `s_clk` edge, the word on `s_data_i` is accepted. `s_ready_o` reads 0 in the following sender cycle.
- R3: While `s_ready_o` is 0, `s_valid_i` and `s_data_i` are ignored. No extra word is delivered and the word in flight is not altered.
- R4: Each accepted word produces exactly one `r_valid_o` pulse, one `r_clk` cycle wide. `r_data_o` carries that word during the pulse.
- R5: Between pulses, `r_data_o` keeps the last delivered word.
- R6: The handshake runs in four phases: request rises, then acknowledge rises, then request falls, then acknowledge falls. `s_ready_o` is never 1 while the request is high.
- R7: Words arrive in the order they were accepted, with none lost or repeated, whether the receiver clock is faster or slower than the sender clock.
- R8: The holding register that drives the crossing bus changes only in a cycle where `s_ready_o` was 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| s_clk | input | 1 | Sender clock |
| s_rst | input | 1 | Sender synchronous reset, active high |
| s_valid_i | input | 1 | Sender offers a word |
| s_data_i | input | DATA_W | Word offered by the sender |
| s_ready_o | output | 1 | Block can accept a word |
| r_clk | input | 1 | Receiver clock |
| r_rst | input | 1 | Receiver synchronous reset, active high |
| r_valid_o | output | 1 | One-cycle pulse: a new word is on r_data_o |
| r_data_o | output | DATA_W | Last delivered word |

## Verification
The bench builds the block with `DATA_W` = 8 and `SYNC_STAGES` = 2. At that width it can send every one of the 256 word values, so a stuck, swapped or cross-coupled bus bit shows up as a data mismatch. It then repeats a 64-word sweep with the receiver clock set much slower than the sender clock, and again with it set faster. This exercises both synchronizer directions at several phase relations. During each handshake it drives junk words while the block is busy, so that a handshake that leaks or re-arms too early delivers an extra word or a wrong one.

// File: rtl/cdc_word_handshake_pkg.sv
package cdc_word_handshake_pkg;
  typedef enum logic [1:0] {
    TX_IDLE      = 2'd0,
    TX_WAIT_ACK  = 2'd1,
    TX_WAIT_DROP = 2'd2
  } tx_state_t;
endpackage

// File: rtl/cdc_word_handshake_sync.sv
module cdc_word_handshake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cdc_word_handshake_tx.sv
module cdc_word_handshake_tx
  import cdc_word_handshake_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  output logic              req_o,
  output logic [DATA_W-1:0] hold_o,
  input  logic              ack_i,
  output logic              ack_seen_o
);
  tx_state_t state;
  logic      ack_seen;

  cdc_word_handshake_sync #(.STAGES(SYNC_STAGES)) ack_sync_i (
    .clk(clk), .rst(rst), .d(ack_i), .q(ack_seen)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= TX_IDLE;
      req_o   <= 1'b0;
      ready_o <= 1'b1;
      hold_o  <= '0;
    end else begin
      case (state)
        TX_IDLE: if (valid_i) begin
          hold_o  <= data_i;
          req_o   <= 1'b1;
          ready_o <= 1'b0;
          state   <= TX_WAIT_ACK;
        end
        TX_WAIT_ACK: if (ack_seen) begin
          req_o <= 1'b0;
          state <= TX_WAIT_DROP;
        end
        TX_WAIT_DROP: if (!ack_seen) begin
          ready_o <= 1'b1;
          state   <= TX_IDLE;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign ack_seen_o = ack_seen;
endmodule

// File: rtl/cdc_word_handshake_rx.sv
module cdc_word_handshake_rx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              ack_o,
  output logic              req_seen_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic req_seen;
  logic req_seen_q;
  logic req_edge;

  cdc_word_handshake_sync #(.STAGES(SYNC_STAGES)) req_sync_i (
    .clk(clk), .rst(rst), .d(req_i), .q(req_seen)
  );

  assign req_edge = req_seen & ~req_seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_seen_q <= 1'b0;
      ack_o      <= 1'b0;
      valid_o    <= 1'b0;
      data_o     <= '0;
    end else begin
      req_seen_q <= req_seen;
      valid_o    <= req_edge;
      if (req_edge) begin
        data_o <= bus_i;
        ack_o  <= 1'b1;
      end else if (!req_seen) begin
        ack_o <= 1'b0;
      end
    end
  end

  assign req_seen_o = req_seen;
endmodule

// File: rtl/cdc_word_handshake.sv
module cdc_word_handshake #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              s_clk,
  input  logic              s_rst,
  input  logic              s_valid_i,
  input  logic [DATA_W-1:0] s_data_i,
  output logic              s_ready_o,
  input  logic              r_clk,
  input  logic              r_rst,
  output logic              r_valid_o,
  output logic [DATA_W-1:0] r_data_o
);
  logic              req;
  logic              ack;
  logic              ack_seen;
  logic              req_seen;
  logic [DATA_W-1:0] hold_data;

  cdc_word_handshake_tx #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) tx_i (
    .clk(s_clk), .rst(s_rst), .valid_i(s_valid_i), .data_i(s_data_i),
    .ready_o(s_ready_o), .req_o(req), .hold_o(hold_data),
    .ack_i(ack), .ack_seen_o(ack_seen)
  );

  cdc_word_handshake_rx #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) rx_i (
    .clk(r_clk), .rst(r_rst), .req_i(req), .bus_i(hold_data),
    .ack_o(ack), .req_seen_o(req_seen), .valid_o(r_valid_o), .data_o(r_data_o)
  );
endmodule

// File: rtl/cdc_word_handshake_chk.sv
module cdc_word_handshake_chk #(
  parameter int DATA_W = 8
) (
  input logic              s_clk,
  input logic              s_rst,
  input logic              s_valid_i,
  input logic              s_ready_o,
  input logic              r_clk,
  input logic              r_rst,
  input logic              r_valid_o,
  input logic              req,
  input logic              ack,
  input logic              req_seen,
  input logic              ack_seen,
  input logic [DATA_W-1:0] hold_data
);
  // R2: accept drops ready and raises the request
  a_r2_accept: assert property (@(posedge s_clk) disable iff (s_rst)
    (s_valid_i && s_ready_o) |=> (!s_ready_o && req));

  // R4: valid pulse lasts one receiver cycle
  a_r4_one_cycle_pulse: assert property (@(posedge r_clk) disable iff (r_rst)
    r_valid_o |=> !r_valid_o);

  // R6: acknowledge rises only while the request is seen high
  a_r6_ack_after_req: assert property (@(posedge r_clk) disable iff (r_rst)
    $rose(ack) |-> req_seen);

  // R6: request falls only once the acknowledge is seen
  a_r6_req_drop_after_ack: assert property (@(posedge s_clk) disable iff (s_rst)
    $fell(req) |-> ack_seen);

  // R6: ready never overlaps an active request
  a_r6_ready_excludes_req: assert property (@(posedge s_clk) disable iff (s_rst)
    s_ready_o |-> !req);

  // R8: holding register is frozen while busy
  a_r8_hold_stable: assert property (@(posedge s_clk) disable iff (s_rst)
    !s_ready_o |=> $stable(hold_data));
endmodule

bind cdc_word_handshake cdc_word_handshake_chk #(.DATA_W(DATA_W)) chk_i (
  .s_clk(s_clk), .s_rst(s_rst), .s_valid_i(s_valid_i), .s_ready_o(s_ready_o),
  .r_clk(r_clk), .r_rst(r_rst), .r_valid_o(r_valid_o),
  .req(req), .ack(ack), .req_seen(req_seen), .ack_seen(ack_seen),
  .hold_data(hold_data)
);

// File: tb/cdc_word_handshake_tb_top.sv
`timescale 1ns/1ps
module cdc_word_handshake_tb_top;
  localparam int DATA_W = 8;

  logic              s_clk = 1'b0;
  logic              r_clk = 1'b0;
  logic              s_rst = 1'b1;
  logic              r_rst = 1'b1;
  logic              s_valid_i = 1'b0;
  logic [DATA_W-1:0] s_data_i = '0;
  logic              s_ready_o;
  logic              r_valid_o;
  logic [DATA_W-1:0] r_data_o;

  real r_half = 3.5;
  int  checks = 0;
  int  fails  = 0;
  int  sent   = 0;
  int  got    = 0;
  int  cycles = 0;
  logic [DATA_W-1:0] expq [0:511];
  logic [DATA_W-1:0] last_data = '0;
  logic              prev_valid = 1'b0;
  logic              done = 1'b0;

  always #2.5 s_clk = ~s_clk;
  always #(r_half) r_clk = ~r_clk;

  cdc_word_handshake #(.DATA_W(DATA_W), .SYNC_STAGES(2)) dut_i (
    .s_clk(s_clk), .s_rst(s_rst), .s_valid_i(s_valid_i), .s_data_i(s_data_i),
    .s_ready_o(s_ready_o), .r_clk(r_clk), .r_rst(r_rst),
    .r_valid_o(r_valid_o), .r_data_o(r_data_o)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Receiver-side monitor: R4, R5, R7
  always @(negedge r_clk) begin
    if (!r_rst && !done) begin
      if (r_valid_o) begin
        checks++;
        if (prev_valid) begin
          fails++;
          $display("FAIL R4 pulse width: actual 2+ cycles expected 1");
        end
        checks++;
        if (got >= sent) begin
          fails++;
          $display("FAIL R3/R7 extra word: actual %0d words expected %0d", got + 1, sent);
        end else if (r_data_o !== expq[got]) begin
          fails++;
          $display("FAIL R7 word %0d: actual %h expected %h", got, r_data_o, expq[got]);
        end
        got++;
        last_data = r_data_o;
      end else begin
        checks++;
        if (r_data_o !== last_data) begin
          fails++;
          $display("FAIL R5 hold: actual %h expected %h", r_data_o, last_data);
        end
      end
      prev_valid = r_valid_o;
    end
  end

  // Watchdog
  always @(posedge s_clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      done = 1'b1;
      report();
    end
  end

  task automatic send(input logic [DATA_W-1:0] d);
    while (!s_ready_o) @(negedge s_clk);
    s_valid_i = 1'b1;
    s_data_i  = d;
    expq[sent] = d;
    sent++;
    @(negedge s_clk);
    checks++;
    if (s_ready_o !== 1'b0) begin
      fails++;
      $display("FAIL R2 ready after accept: actual %b expected 0", s_ready_o);
    end
    // R3: junk offered while busy must be ignored
    s_data_i = ~d;
    @(negedge s_clk);
    s_valid_i = 1'b0;
    s_data_i  = d ^ 8'h5A;
  endtask

  task automatic drain();
    int wait_cnt = 0;
    while (got != sent && wait_cnt < 2000) begin
      @(negedge s_clk);
      wait_cnt++;
    end
    checks++;
    if (got != sent) begin
      fails++;
      $display("FAIL R7 count: actual %0d expected %0d", got, sent);
    end
  endtask

  initial begin
    repeat (6) @(negedge s_clk);
    s_rst = 1'b0;
    r_rst = 1'b0;
    repeat (3) @(negedge s_clk);
    checks++;
    if (s_ready_o !== 1'b1 || r_valid_o !== 1'b0 || r_data_o !== '0) begin
      fails++;
      $display("FAIL R1 reset: actual rdy=%b vld=%b dat=%h expected 1 0 00",
               s_ready_o, r_valid_o, r_data_o);
    end

    // Phase A: every word value, receiver slightly slower
    for (int v = 0; v < 256; v++) send(v[DATA_W-1:0]);
    drain();

    // Phase B: much slower receiver
    r_half = 11.5;
    for (int v = 0; v < 64; v++) send(8'(v * 37 + 11));
    drain();

    // Phase C: faster receiver
    r_half = 1.5;
    for (int v = 0; v < 64; v++) send(8'(255 - v * 3));
    drain();

    // R3: junk held while idle-returning must not add words beyond sent
    repeat (20) @(negedge s_clk);
    checks++;
    if (got != sent) begin
      fails++;
      $display("FAIL R3 final count: actual %0d expected %0d", got, sent);
    end
    done = 1'b1;
    report();
  end
endmodule